// File: doc/BRIEF.md
# Dual-Slope-Direction Ramp Converter Sequencer

This block runs the digital side of a converter built from a logic device, a passive RC network and a differential input used as a comparator. It drives a square wave into the RC network, which makes a reference that rises for one half period and falls for the next. A time-to-digital converter elsewhere timestamps each comparator edge, produced when the reference crosses the analog input, and passes the timestamp in on a valid strobe. The block subtracts the start time of the current ramp to get a fine-bin offset. It tags the result with the ramp direction and looks up a voltage code in a table with separate entries for each direction. This lets a strongly exponential falling ramp be corrected, and it gives finer steps near zero.

Both ramps are sampled, so each reference period yields two samples, and these are not evenly spaced in time. Each output sample therefore carries its crossing timestamp. A ramp with no crossing produces a flagged saturated sample at that ramp's extreme. A crossing that falls outside the current ramp, or a second crossing in the same ramp, is dropped and counted.

Top module: `ramp_adc_seq`

## Requirements
- R1: `ref_drive` is 1 in the first cycle after reset release and inverts every 16 clock cycles. While it is 1 the ramp is rising (direction 0). While it is 0 the ramp is falling (direction 1).
- R2: Timestamps count fine bins of a quarter clock cycle. Half period k after reset release starts at timestamp 64·k (mod 2^16). The offset of a crossing is (ts_time − start) mod 2^16, and it is in window when it is below 64.
- R3: An accepted crossing on a rising ramp with offset o yields code 4·o + 2.
- R4: An accepted crossing on a falling ramp with offset o yields code m_o >> 8, where m_0 = 255·256 and m_(i+1) = (m_i·240) >> 8.
- R5: An accepted crossing presented in cycle n appears in cycle n+1 with `smp_valid`=1, `smp_sat`=0, `smp_dir` equal to the ramp direction, and `smp_time` equal to the timestamp. In cycles without a sample, `smp_valid` is 0.
- R6: Only the first in-window crossing of a half period is accepted. Any later crossing in the same half period is discarded and adds one to `err_count`.
- R7: A crossing whose offset is 64 or more is discarded and adds one to `err_count`.
- R8: If a half period ends with no accepted crossing, a sample appears in the cycle after its last cycle with `smp_sat`=1. Its code is 255 on a rising ramp and 0 on a falling ramp, and its time is start + 63.
- R9: A crossing accepted in the last cycle of a half period produces a normal sample and no saturated sample.
- R10: `err_count` saturates at 255.
- R11: During reset `smp_valid` is 0, `err_count` is 0 and `ref_drive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Crossing timestamp strobe |
| ts_time | input | 16 | Crossing time in fine bins |
| ref_drive | output | 1 | Square-wave drive into the RC network |
| smp_valid | output | 1 | Output sample strobe |
| smp_code | output | 8 | Corrected voltage code |
| smp_dir | output | 1 | Ramp direction of the sample, 1 = falling |
| smp_sat | output | 1 | No crossing in the ramp, code at the extreme |
| smp_time | output | 16 | Crossing time, or ramp end for saturated samples |
| err_count | output | 8 | Saturating count of discarded crossings |

## Verification
Each stimulus pattern is applied to both ramp directions. A single crossing at a moving offset separates the rising table from the falling table and shows whether the start time is subtracted correctly. A ramp left empty, and a crossing in the very last cycle, separate a true saturation from one raised by mistake. Pairs that include a duplicate crossing, or a crossing one bin before or after the window, separate the accept rule from the error count. A final storm of out-of-window stamps drives the error count to its ceiling.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

   // rising ramp: near-linear, bin centred in the code range
   function automatic int rise_code(int o, int code_w, int ofs_w);
      return (o << (code_w - ofs_w)) + (1 << (code_w - ofs_w - 1));
   endfunction

   // falling ramp, exponential decay per bin with factor k/256
   function automatic int fall_exp_code(int o, int code_w, int k);
      int m;
      m = ((1 << code_w) - 1) << 8;
      for (int i = 0; i < o; i++) m = (m * k) >> 8;
      return m >> 8;
   endfunction

   // falling ramp treated as linear mirror of the rising one
   function automatic int fall_lin_code(int o, int code_w, int ofs_w);
      return ((1 << code_w) - 1) - rise_code(o, code_w, ofs_w);
   endfunction

endpackage

// File: rtl/ramp_timer.sv
module ramp_timer #(
   parameter int TS_W        = 16,
   parameter int HALF_CYCLES = 16,
   parameter int FINE_BITS   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic            drive,
   output logic            dir,
   output logic            last_cyc,
   output logic [TS_W-1:0] start_ts
);
   localparam int PH_W      = $clog2(HALF_CYCLES);
   localparam int HALF_BINS = HALF_CYCLES << FINE_BITS;

   logic [PH_W-1:0] ph;

   assign last_cyc = (ph == PH_W'(HALF_CYCLES - 1));
   assign dir      = ~drive;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= '0;
         drive    <= 1'b1;
         start_ts <= '0;
      end else if (last_cyc) begin
         ph       <= '0;
         drive    <= ~drive;
         start_ts <= start_ts + TS_W'(HALF_BINS);
      end else begin
         ph <= ph + 1'b1;
      end
   end
endmodule

// File: rtl/crossing_gate.sv
module crossing_gate #(
   parameter int TS_W  = 16,
   parameter int OFS_W = 6,
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ts_valid,
   input  logic [TS_W-1:0]  ts_time,
   input  logic [TS_W-1:0]  start_ts,
   input  logic             last_cyc,
   output logic             acc,
   output logic             sat_fire,
   output logic [OFS_W-1:0] ofs,
   output logic [ERR_W-1:0] err_count
);
   logic [TS_W-1:0] diff;
   logic            in_win;
   logic            got;
   logic            bad;

   assign diff     = ts_time - start_ts;
   assign in_win   = (diff[TS_W-1:OFS_W] == '0);
   assign ofs      = diff[OFS_W-1:0];
   assign acc      = ts_valid && in_win && !got;
   assign bad      = ts_valid && !acc;
   assign sat_fire = last_cyc && !got && !acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         got       <= 1'b0;
         err_count <= '0;
      end else begin
         got <= last_cyc ? 1'b0 : (got | acc);
         if (bad && (err_count != '1)) err_count <= err_count + 1'b1;
      end
   end
endmodule

// File: rtl/code_rom.sv
module code_rom
   import ramp_adc_pkg::*;
#(
   parameter int OFS_W    = 6,
   parameter int CODE_W   = 8,
   parameter bit FALL_EXP = 1'b1,
   parameter int DECAY_K  = 240
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [OFS_W:0]    addr,
   output logic [CODE_W-1:0] q
);
   localparam int HALF_BINS = 1 << OFS_W;
   localparam int DEPTH     = 2 * HALF_BINS;

   logic [CODE_W-1:0] tbl [DEPTH];

   for (genvar i = 0; i < HALF_BINS; i++) begin : g_ent
      assign tbl[i] = CODE_W'(rise_code(i, CODE_W, OFS_W));
      if (FALL_EXP) begin : g_exp
         assign tbl[HALF_BINS+i] = CODE_W'(fall_exp_code(i, CODE_W, DECAY_K));
      end else begin : g_lin
         assign tbl[HALF_BINS+i] = CODE_W'(fall_lin_code(i, CODE_W, OFS_W));
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) q <= tbl[addr];
   end
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq #(
   parameter int TS_W        = 16,
   parameter int HALF_CYCLES = 16,
   parameter int FINE_BITS   = 2,
   parameter int CODE_W      = 8,
   parameter int ERR_W       = 8,
   parameter bit FALL_EXP    = 1'b1,
   parameter int DECAY_K     = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ts_valid,
   input  logic [TS_W-1:0]   ts_time,
   output logic              ref_drive,
   output logic              smp_valid,
   output logic [CODE_W-1:0] smp_code,
   output logic              smp_dir,
   output logic              smp_sat,
   output logic [TS_W-1:0]   smp_time,
   output logic [ERR_W-1:0]  err_count
);
   localparam int OFS_W     = $clog2(HALF_CYCLES) + FINE_BITS;
   localparam int HALF_BINS = 1 << OFS_W;

   if ((1 << $clog2(HALF_CYCLES)) != HALF_CYCLES || HALF_CYCLES < 2) begin : g_bad_half
      $error("HALF_CYCLES must be a power of two of at least 2");
   end
   if (CODE_W <= OFS_W) begin : g_bad_code
      $error("CODE_W must exceed the offset width");
   end
   if (TS_W <= OFS_W) begin : g_bad_ts
      $error("TS_W must exceed the offset width");
   end
   if (DECAY_K < 1 || DECAY_K > 255) begin : g_bad_k
      $error("DECAY_K must lie in 1..255");
   end

   logic              dir;
   logic              last_cyc;
   logic [TS_W-1:0]   start_ts;
   logic              acc;
   logic              sat_fire;
   logic [OFS_W-1:0]  ofs;
   logic [CODE_W-1:0] rom_q;

   ramp_timer #(
      .TS_W(TS_W), .HALF_CYCLES(HALF_CYCLES), .FINE_BITS(FINE_BITS)
   ) timer_i (
      .clk(clk), .rst_n(rst_n), .drive(ref_drive), .dir(dir),
      .last_cyc(last_cyc), .start_ts(start_ts)
   );

   crossing_gate #(
      .TS_W(TS_W), .OFS_W(OFS_W), .ERR_W(ERR_W)
   ) gate_i (
      .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_time(ts_time),
      .start_ts(start_ts), .last_cyc(last_cyc), .acc(acc),
      .sat_fire(sat_fire), .ofs(ofs), .err_count(err_count)
   );

   code_rom #(
      .OFS_W(OFS_W), .CODE_W(CODE_W), .FALL_EXP(FALL_EXP), .DECAY_K(DECAY_K)
   ) rom_i (
      .clk(clk), .rd_en(acc), .addr({dir, ofs}), .q(rom_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_sat   <= 1'b0;
         smp_dir   <= 1'b0;
         smp_time  <= '0;
      end else begin
         smp_valid <= acc | sat_fire;
         smp_sat   <= sat_fire;
         if (acc | sat_fire) begin
            smp_dir  <= dir;
            smp_time <= acc ? ts_time : (start_ts + TS_W'(HALF_BINS - 1));
         end
      end
   end

   assign smp_code = smp_sat ? (smp_dir ? '0 : '1) : rom_q;
endmodule

module ramp_adc_seq_chk #(
   parameter int HALF_CYCLES = 16,
   parameter int CODE_W      = 8,
   parameter int ERR_W       = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_drive,
   input logic              smp_valid,
   input logic              smp_sat,
   input logic              smp_dir,
   input logic [CODE_W-1:0] smp_code,
   input logic [ERR_W-1:0]  err_count
);
   localparam int PH_W = $clog2(HALF_CYCLES);
   logic [PH_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (cnt == PH_W'(HALF_CYCLES - 1)) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   assert_drive_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == PH_W'(HALF_CYCLES - 1)) |=> (ref_drive != $past(ref_drive)));

   assert_drive_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != PH_W'(HALF_CYCLES - 1)) |=> $stable(ref_drive));

   assert_sat_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_sat |-> smp_valid);

   assert_sat_extreme_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_sat) |-> (smp_code == (smp_dir ? {CODE_W{1'b0}} : {CODE_W{1'b1}})));

   assert_dir_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (smp_dir == !$past(ref_drive)));

   assert_err_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == $past(err_count)) || (err_count == ERR_W'($past(err_count) + 1'b1)));
endmodule

bind ramp_adc_seq ramp_adc_seq_chk #(
   .HALF_CYCLES(HALF_CYCLES), .CODE_W(CODE_W), .ERR_W(ERR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ref_drive(ref_drive), .smp_valid(smp_valid),
   .smp_sat(smp_sat), .smp_dir(smp_dir), .smp_code(smp_code), .err_count(err_count)
);

// File: tb/ramp_adc_seq_tb_top.sv
module ramp_adc_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ts_valid = 1'b0;
   logic [15:0] ts_time = '0;
   logic        ref_drive;
   logic        smp_valid;
   logic [7:0]  smp_code;
   logic        smp_dir;
   logic        smp_sat;
   logic [15:0] smp_time;
   logic [7:0]  err_count;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ramp_adc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_time(ts_time),
      .ref_drive(ref_drive), .smp_valid(smp_valid), .smp_code(smp_code),
      .smp_dir(smp_dir), .smp_sat(smp_sat), .smp_time(smp_time),
      .err_count(err_count)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic int ref_code(int d, int o);
      int m;
      if (d == 0) return 4 * o + 2;
      m = 255 * 256;
      for (int i = 0; i < o; i++) m = (m * 240) / 256;
      return m / 256;
   endfunction

   initial begin
      // reference model state
      int  e_valid, e_code, e_dir, e_sat, e_time, e_err, got;
      int  half, ph, dir, st, kase, tv, v, d;
      localparam int TOTAL = 72 * 16 + 300;
      e_valid = 0; e_code = 0; e_dir = 0; e_sat = 0; e_time = 0; e_err = 0; got = 0;

      repeat (4) @(negedge clk);
      chk(smp_valid == 1'b0, "R11 valid in reset", int'(smp_valid), 0);
      chk(err_count == 8'd0, "R11 errors in reset", int'(err_count), 0);
      chk(ref_drive == 1'b1, "R11 drive in reset", int'(ref_drive), 1);

      for (int n = 0; n < TOTAL; n++) begin
         @(negedge clk);
         rst_n = 1'b1;
         half = n / 16;
         ph   = n % 16;
         dir  = half % 2;
         st   = (half * 64) % 65536;

         // compare outputs of this cycle
         chk(int'(ref_drive) == (dir == 0 ? 1 : 0), "R1 drive", int'(ref_drive), dir == 0 ? 1 : 0);
         chk(int'(smp_valid) == e_valid, e_sat != 0 ? "R8 valid" : "R5 valid", int'(smp_valid), e_valid);
         chk(int'(err_count) == e_err, e_err == 255 ? "R10 errors" : "R6,R7 errors", int'(err_count), e_err);
         if (e_valid != 0) begin
            chk(int'(smp_sat) == e_sat, e_sat != 0 ? "R8 sat flag" : "R9 sat flag", int'(smp_sat), e_sat);
            chk(int'(smp_dir) == e_dir, "R5 dir", int'(smp_dir), e_dir);
            chk(int'(smp_code) == e_code,
                e_sat != 0 ? "R8 code" : (e_dir != 0 ? "R4,R2 code" : "R3,R2 code"),
                int'(smp_code), e_code);
            chk(int'(smp_time) == e_time, e_sat != 0 ? "R8 time" : "R5 time", int'(smp_time), e_time);
         end

         // stimulus for this cycle
         kase = (half < 72) ? (half / 2) % 6 : 6;
         v = 0; tv = 0;
         case (kase)
            0: if (ph == 3) begin v = 1; tv = st + ((half * 7 + 5) % 64); end
            2: if (ph == 0) begin v = 1; tv = st; end                 // offset 0
               else if (ph == 5) begin v = 1; tv = st + 10; end       // duplicate, R6
            3: if (ph == 15) begin v = 1; tv = st + 63; end           // last cycle, R9
            4: if (ph == 2) begin v = 1; tv = st + 64; end            // one past window, R7
               else if (ph == 4) begin v = 1; tv = st - 1; end        // one before window, R7
               else if (ph == 8) begin v = 1; tv = st + ((half * 11) % 64); end
            5: if (ph == 6) begin v = 1; tv = st + ((half * 3) % 64); end
            6: begin v = 1; tv = st + 200; end                        // error storm, R10
            default: v = 0;                                           // kase 1: empty ramp, R8
         endcase
         tv = tv & 16'hFFFF;
         ts_valid = (v != 0);
         ts_time  = 16'(tv);

         // model update
         e_valid = 0; e_sat = 0;
         d = (tv - st) & 16'hFFFF;
         if (v != 0 && got == 0 && d < 64) begin
            got = 1;
            e_valid = 1; e_dir = dir; e_time = tv; e_code = ref_code(dir, d);
         end else if (v != 0) begin
            if (e_err < 255) e_err++;
         end
         if (ph == 15) begin
            if (got == 0) begin
               e_valid = 1; e_sat = 1; e_dir = dir;
               e_code = (dir == 0) ? 255 : 0;
               e_time = (st + 63) & 16'hFFFF;
            end
            got = 0;
         end
      end
      @(negedge clk);
      ts_valid = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule